// File: doc/BRIEF.md
# Battery Backup Supply Selector

This block decides whether the device draws power from its main rail or from a backup battery. Both voltages arrive as unsigned millivolt codes. Each new pair of codes comes with a one-cycle valid strobe. The block holds a registered supply state. It drives a supply-select output and a matching backup-active flag from that state.

A policy input selects one of two switching rules. Both rules use hysteresis.

- In the comparative policy (policy bit high), the block moves to the battery once the main rail falls clearly below the battery. It moves back once the main rail rises clearly above it.
- In the trip-gated policy (policy bit low), moving to the battery also needs the main rail to be under a fixed trip level. Moving back needs either of two things: the main rail clears the battery by the margin, or it clears the trip level by a separate margin.

The policy bit is read only when a sample is evaluated. Changing it never forces a switch by itself.

Top module: `supply_selector`

## Requirements
- R1: A synchronous reset puts the block in main-supply state; supply_sel and backup_active are 0 on the cycle after reset.
- R2: On a cycle where sample_vld is 0, the state is unchanged regardless of the voltage codes or the policy bit.
- R3: With policy_cmp = 0 (trip-gated), main-supply state moves to battery only when main_mv < batt_mv − 50 and main_mv < 2200, both strict.
- R4: With policy_cmp = 0, battery state returns to main when main_mv > batt_mv + 50 or main_mv > 2230 (trip 2200 plus 30), both strict.
- R5: With policy_cmp = 1 (comparative), main-supply state moves to battery exactly when main_mv < batt_mv − 50 (strict); the trip level is ignored.
- R6: With policy_cmp = 1, battery state returns to main exactly when main_mv > batt_mv + 50 (strict). While the battery stays above the main rail, the block stays on battery indefinitely.
- R7: The batt_mv − 50 term saturates at zero, so a battery code at or below 50 can never cause a move to battery.
- R8: A change of policy_cmp takes effect only at the next valid sample, and that sample is judged under the new policy.
- R9: supply_sel and backup_active are both 1 exactly when the state is battery and both 0 in main-supply state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_vld | input | 1 | Voltage codes are valid this cycle |
| main_mv | input | 13 | Main rail voltage in mV |
| batt_mv | input | 13 | Battery voltage in mV |
| policy_cmp | input | 1 | 1 = comparative policy, 0 = trip-gated policy |
| supply_sel | output | 1 | 1 = run from battery, 0 = run from main rail |
| backup_active | output | 1 | 1 while on battery |

## Verification
Two events can meet in one cycle: a flip of the policy bit and a valid sample. The trip level is the point where the two policies diverge. The bench therefore flips policy_cmp in the same cycle as a sample whose main code sits between the trip level and the battery threshold. The next output must follow the new policy, not the old one.

Random traffic toggles the policy bit and the strobe freely on codes clustered near every threshold. A reference model in the bench, fed the same inputs, judges each cycle.

// File: rtl/supsel_pkg.sv
package supsel_pkg;
   typedef enum logic {
      SRC_MAIN = 1'b0,
      SRC_BATT = 1'b1
   } src_e;
endpackage

// File: rtl/supsel_thresh.sv
module supsel_thresh #(
   parameter int W          = 13,
   parameter int BAT_HYS_MV = 50
) (
   input  logic [W-1:0] batt_mv,
   output logic [W-1:0] batt_lo,
   output logic [W:0]   batt_hi
);
   localparam logic [W-1:0] HYS_N = W'(BAT_HYS_MV);
   localparam logic [W:0]   HYS_W = (W+1)'(BAT_HYS_MV);

   generate
      if (BAT_HYS_MV == 0) begin : g_nohys
         assign batt_lo = batt_mv;
      end else begin : g_sat
         assign batt_lo = (batt_mv > HYS_N) ? (batt_mv - HYS_N) : '0;
      end
   endgenerate

   assign batt_hi = {1'b0, batt_mv} + HYS_W;
endmodule

// File: rtl/supsel_policy.sv
module supsel_policy #(
   parameter int W           = 13,
   parameter int TRIP_MV     = 2200,
   parameter int TRIP_HYS_MV = 30
) (
   input  logic [W-1:0] main_mv,
   input  logic [W-1:0] batt_lo,
   input  logic [W:0]   batt_hi,
   input  logic         policy_cmp,
   output logic         go_batt,
   output logic         go_main
);
   localparam logic [W-1:0] TRIP_LO = W'(TRIP_MV);
   localparam logic [W:0]   TRIP_HI = (W+1)'(TRIP_MV + TRIP_HYS_MV);

   logic [W:0] main_w;
   logic below_batt, above_batt, below_trip, above_trip;

   assign main_w     = {1'b0, main_mv};
   assign below_batt = main_mv < batt_lo;
   assign above_batt = main_w > batt_hi;
   assign below_trip = main_mv < TRIP_LO;
   assign above_trip = main_w > TRIP_HI;

   always_comb begin
      if (policy_cmp) begin
         go_batt = below_batt;
         go_main = above_batt;
      end else begin
         go_batt = below_batt & below_trip;
         go_main = above_batt | above_trip;
      end
   end
endmodule

// File: rtl/supply_selector.sv
module supply_selector
   import supsel_pkg::*;
#(
   parameter int W           = 13,
   parameter int TRIP_MV     = 2200,
   parameter int TRIP_HYS_MV = 30,
   parameter int BAT_HYS_MV  = 50
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         sample_vld,
   input  logic [W-1:0] main_mv,
   input  logic [W-1:0] batt_mv,
   input  logic         policy_cmp,
   output logic         supply_sel,
   output logic         backup_active
);
   localparam int CODE_MAX = (1 << W) - 1;

   generate
      if (W < 2 || W > 20) begin : g_bad_w
         $error("supply_selector: W out of range");
      end
      if (TRIP_MV + TRIP_HYS_MV > CODE_MAX) begin : g_bad_trip
         $error("supply_selector: trip level exceeds code range");
      end
      if (BAT_HYS_MV < 0 || BAT_HYS_MV > CODE_MAX) begin : g_bad_hys
         $error("supply_selector: battery hysteresis out of range");
      end
   endgenerate

   logic [W-1:0] batt_lo;
   logic [W:0]   batt_hi;
   logic         go_batt, go_main;
   src_e         src_q, src_d;

   supsel_thresh #(.W(W), .BAT_HYS_MV(BAT_HYS_MV)) u_thresh (
      .batt_mv (batt_mv),
      .batt_lo (batt_lo),
      .batt_hi (batt_hi)
   );

   supsel_policy #(.W(W), .TRIP_MV(TRIP_MV), .TRIP_HYS_MV(TRIP_HYS_MV)) u_policy (
      .main_mv    (main_mv),
      .batt_lo    (batt_lo),
      .batt_hi    (batt_hi),
      .policy_cmp (policy_cmp),
      .go_batt    (go_batt),
      .go_main    (go_main)
   );

   always_comb begin
      src_d = src_q;
      if (sample_vld) begin
         if (src_q == SRC_MAIN && go_batt)      src_d = SRC_BATT;
         else if (src_q == SRC_BATT && go_main) src_d = SRC_MAIN;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) src_q <= SRC_MAIN;
      else     src_q <= src_d;
   end

   assign supply_sel    = (src_q == SRC_BATT);
   assign backup_active = (src_q == SRC_BATT);

   // Reference conditions written from the ports in signed integer form
   int m_i, b_i;
   assign m_i = int'(main_mv);
   assign b_i = int'(batt_mv);

   assert_reset_main_R1: assert property (@(posedge clk) rst |=> !supply_sel && !backup_active);

   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !sample_vld |=> $stable(supply_sel));

   assert_std_enter_R3: assert property (@(posedge clk) disable iff (rst)
      (sample_vld && !policy_cmp && !supply_sel) |=>
      (supply_sel == ($past(m_i) < $past(b_i) - BAT_HYS_MV && $past(m_i) < TRIP_MV)));

   assert_std_leave_R4: assert property (@(posedge clk) disable iff (rst)
      (sample_vld && !policy_cmp && supply_sel) |=>
      (!supply_sel == ($past(m_i) > $past(b_i) + BAT_HYS_MV ||
                       $past(m_i) > TRIP_MV + TRIP_HYS_MV)));

   assert_cmp_enter_R5: assert property (@(posedge clk) disable iff (rst)
      (sample_vld && policy_cmp && !supply_sel) |=>
      (supply_sel == ($past(m_i) < $past(b_i) - BAT_HYS_MV)));

   assert_cmp_leave_R6: assert property (@(posedge clk) disable iff (rst)
      (sample_vld && policy_cmp && supply_sel) |=>
      (!supply_sel == ($past(m_i) > $past(b_i) + BAT_HYS_MV)));

   assert_flags_agree_R9: assert property (@(posedge clk) disable iff (rst)
      supply_sel == backup_active);
endmodule

// File: tb/test_supply_selector.sv
`timescale 1ns/1ps
module test_supply_selector;
   localparam int W = 13;

   logic         clk = 1'b0;
   logic         rst;
   logic         sample_vld;
   logic [W-1:0] main_mv, batt_mv;
   logic         policy_cmp;
   logic         supply_sel, backup_active;

   int n_checks = 0;
   int n_fails  = 0;
   bit exp_batt = 1'b0;

   always #2.5 clk = ~clk;

   supply_selector i_supply_selector (
      .clk           (clk),
      .rst           (rst),
      .sample_vld    (sample_vld),
      .main_mv       (main_mv),
      .batt_mv       (batt_mv),
      .policy_cmp    (policy_cmp),
      .supply_sel    (supply_sel),
      .backup_active (backup_active)
   );

   function automatic bit model(bit cur, bit vld, int m, int b, bit cmp);
      bit lo, hi;
      if (!vld) return cur;
      lo = (m < b - 50);
      hi = (m > b + 50);
      if (!cmp) begin
         lo = lo && (m < 2200);
         hi = hi || (m > 2230);
      end
      if (!cur && lo) return 1'b1;
      if (cur && hi)  return 1'b0;
      return cur;
   endfunction

   task automatic check(string req, bit exp);
      n_checks++;
      if (supply_sel !== exp || backup_active !== exp) begin
         n_fails++;
         $display("FAIL %s: supply_sel=%0b backup_active=%0b expected %0b",
                  req, supply_sel, backup_active, exp);
      end
   endtask

   // called at a negedge: apply inputs, advance to next negedge, check
   task automatic step(string req, bit vld, int m, int b, bit cmp);
      sample_vld = vld;
      main_mv    = W'(m);
      batt_mv    = W'(b);
      policy_cmp = cmp;
      exp_batt   = model(exp_batt, vld, m, b, cmp);
      @(negedge clk);
      check(req, exp_batt);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      sample_vld = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      exp_batt = 1'b0;
   endtask

   initial begin
      #(200000 * 5.0);
      n_fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      int seed;
      rst = 1'b1; sample_vld = 1'b0; main_mv = '0; batt_mv = '0; policy_cmp = 1'b1;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      check("R1 reset state", 1'b0);

      // R5/R6 comparative boundaries
      step("R5 equal margin no switch", 1, 2950, 3000, 1);
      step("R5 enter battery", 1, 2949, 3000, 1);
      step("R6 stay on battery", 1, 1000, 3000, 1);
      step("R6 at margin stays", 1, 3050, 3000, 1);
      step("R6 return to main", 1, 3051, 3000, 1);
      // R2 hold while strobe low
      step("R2 hold no strobe", 0, 100, 3000, 1);
      step("R2 hold no strobe", 0, 100, 3000, 0);
      // R3 trip gating
      step("R3 at trip no switch", 1, 2200, 3000, 0);
      step("R3 enter below trip", 1, 2199, 3000, 0);
      // R4 trip-side leave
      step("R4 at trip margin stays", 1, 2230, 3000, 0);
      step("R4 leave above trip margin", 1, 2231, 3000, 0);
      // R4 battery-side leave with low battery
      step("R3 enter low battery", 1, 1000, 1200, 0);
      step("R4 leave above battery", 1, 1251, 1200, 0);
      // R7 saturation
      step("R7 saturated no switch", 1, 0, 50, 1);
      step("R7 saturated no switch", 1, 0, 30, 0);
      step("R7 just above saturation", 1, 0, 51, 1);
      do_reset();
      check("R1 reset from battery", 1'b0);
      // R8 policy flip coincident with sample: main between trip and battery
      step("R8 trip-gated blocks", 1, 2500, 3000, 0);
      step("R8 flip to comparative enters", 1, 2500, 3000, 1);
      step("R8 flip to trip-gated leaves", 1, 2500, 3000, 0);
      step("R8 flip without strobe holds", 0, 2500, 3000, 1);
      step("R8 next sample uses new policy", 1, 2500, 3000, 1);

      // random traffic near thresholds
      seed = $urandom(32'h5eed_1234);
      for (int i = 0; i < 3000; i++) begin
         int b, m, pick;
         bit vld, cmp;
         b    = 1500 + int'($urandom_range(0, 2000));
         pick = int'($urandom_range(0, 3));
         case (pick)
            0: m = b - 60 + int'($urandom_range(0, 120));
            1: m = 2170 + int'($urandom_range(0, 90));
            2: m = int'($urandom_range(0, 4000));
            default: m = b - 52 + int'($urandom_range(0, 4));
         endcase
         if (m < 0) m = 0;
         vld = ($urandom_range(0, 3) != 0);
         cmp = $urandom_range(0, 1) == 1;
         if (i % 500 == 499) begin
            do_reset();
            check("R1 reset mid-run", 1'b0);
         end else begin
            step(cmp ? "R5/R6 random" : "R3/R4 random", vld, m, b, cmp);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule